// File: doc/BRIEF.md
# Address-Space-Tagged Page Translation Buffer

This block is a small fully associative buffer of page translations. Every slot stores a virtual page tag, a physical page number, two per-mode permission masks (one for reads, one for writes), a fault-on-read flag, a fault-on-write flag, an address-space number and a global flag. The global flag makes the slot match in every address space. A lookup takes a virtual page number and the current address-space number. In the same cycle it returns a hit flag, a one-hot hit vector, the physical page and the stored attribute fields. The block does not evaluate permissions. The fields are handed to the caller as they are.

Maintenance operations all complete in one clock:
- Insert places a new translation at the slot named by a round-robin replacement pointer. Before it does, it removes any older copy of the same virtual page.
- Flush-all empties the table.
- Flush-process drops every slot that is not global.
- Flush-address drops only the slots that a given page and space would hit.

A register-style port shows the slot under the replacement pointer as one packed 64-bit word. A strobe on that port moves the pointer on by one.

Top module: `xlat_buf`

## Requirements
- R1: A slot hits a lookup only when it is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored space number equals `lk_asn`.
- R2: `lk_hit_vec` has at most one bit set, and that bit is the lowest-indexed hitting slot. `lk_hit` is set exactly when the vector is non-zero. The field outputs show that slot, and all of them read zero on a miss.
- R3: An insert (`wr_en`) writes the supplied fields and tag into the slot at `rb_ptr` and marks it valid. The pointer then advances by one, and it wraps from DEPTH-1 to 0.
- R4: An insert first invalidates every valid slot whose tag equals `wr_vpn`, whatever its space number, so a page never has two copies.
- R5: `fl_all` invalidates and zeroes every slot and sets `rb_ptr` to 0.
- R6: `fl_proc` invalidates every valid slot whose global flag is clear, and leaves global slots untouched.
- R7: `fl_addr` invalidates exactly the slots that would hit a lookup of (`fl_vpn`, `fl_asn`) under R1. Global slots with that tag are included.
- R8: `rb_word` packs the slot at `rb_ptr` with these field positions:
  - physical page at bits 32..58;
  - read mask at bits 8..11;
  - write mask at bits 12..15;
  - fault-on-read at bit 1;
  - fault-on-write at bit 2;
  - global flag at bit 4;
  - space number at bits 57..63.

  All other bits are zero. The physical page field and the space number field overlap at bits 57..58, and the two are ORed there.
- R9: `rb_adv` advances `rb_ptr` by one, with the wrap of R3, and changes no slot. When `rb_adv` and an accepted insert arrive together, the pointer advances once.
- R10: If any flush is requested in the same cycle as an insert, the insert is ignored: nothing is written and the pointer does not advance for it.
- R11: After reset no slot is valid, `rb_ptr` is 0 and `rb_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_hit_vec | output | DEPTH | One-hot hitting slot |
| lk_ppn | output | PPN_W | Physical page of hit |
| lk_rdm | output | MODES | Read-enable mask of hit |
| lk_wrm | output | MODES | Write-enable mask of hit |
| lk_for | output | 1 | Fault-on-read of hit |
| lk_fow | output | 1 | Fault-on-write of hit |
| lk_glb | output | 1 | Global flag of hit |
| wr_en | input | 1 | Insert strobe |
| wr_vpn | input | VPN_W | Insert tag |
| wr_ppn | input | PPN_W | Insert physical page |
| wr_rdm | input | MODES | Insert read mask |
| wr_wrm | input | MODES | Insert write mask |
| wr_for | input | 1 | Insert fault-on-read |
| wr_fow | input | 1 | Insert fault-on-write |
| wr_glb | input | 1 | Insert global flag |
| wr_asn | input | ASN_W | Insert space number |
| fl_all | input | 1 | Flush every slot |
| fl_proc | input | 1 | Flush non-global slots |
| fl_addr | input | 1 | Flush slots hitting fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Flush-address page |
| fl_asn | input | ASN_W | Flush-address space |
| rb_adv | input | 1 | Advance replacement pointer |
| rb_ptr | output | PTR_W | Replacement pointer |
| rb_word | output | 64 | Packed slot at pointer |

## Verification
The bench targets six corner cases:
- **Space mismatch.** A non-global slot is looked up with the wrong space number. A design that ignored the space number would report a false hit.
- **Global slot.** A global slot is looked up under a foreign space number. A design that ignored the global flag would report a miss.
- **Reinserted page.** A page is inserted again under a new space number. If the dedupe were missing, the stale copy would keep hitting under the old space number.
- **Flush plus insert.** An insert arrives together with a flush. A design that honoured the insert would show the new page and an advanced pointer.
- **Flush-address.** One flush uses a wrong space number and another targets a global slot. A sloppy match would either kill too much or miss the global slot.
- **Pointer wrap and packing.** The pointer is driven through its wrap, and hand-packed words are compared with `rb_word`. Misplaced fields or an off-by-one wrap show up directly in those comparisons.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int PK_W        = 64;
   localparam int PK_FOR_BIT  = 1;
   localparam int PK_FOW_BIT  = 2;
   localparam int PK_GLB_BIT  = 4;
   localparam int PK_RDM_LSB  = 8;
   localparam int PK_WRM_LSB  = 12;
   localparam int PK_PPN_LSB  = 32;
   localparam int PK_ASN_LSB  = 57;
   localparam int PK_PPN_MAX  = 27;
   localparam int PK_ASN_MAX  = 7;
   localparam int PK_MASK_MAX = 4;
endpackage

// File: rtl/xlat_slot.sv
module xlat_slot #(
   parameter int VPN_W = 30,
   parameter int PPN_W = 27,
   parameter int ASN_W = 7,
   parameter int MODES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_go,
   input  logic             kill,
   input  logic             clear,
   input  logic [VPN_W-1:0] d_vpn,
   input  logic [PPN_W-1:0] d_ppn,
   input  logic [MODES-1:0] d_rdm,
   input  logic [MODES-1:0] d_wrm,
   input  logic             d_for,
   input  logic             d_fow,
   input  logic             d_glb,
   input  logic [ASN_W-1:0] d_asn,
   input  logic [VPN_W-1:0] a_vpn,
   input  logic [ASN_W-1:0] a_asn,
   input  logic [VPN_W-1:0] b_vpn,
   input  logic [ASN_W-1:0] b_asn,
   output logic             q_vld,
   output logic [VPN_W-1:0] q_vpn,
   output logic [PPN_W-1:0] q_ppn,
   output logic [MODES-1:0] q_rdm,
   output logic [MODES-1:0] q_wrm,
   output logic             q_for,
   output logic             q_fow,
   output logic             q_glb,
   output logic [ASN_W-1:0] q_asn,
   output logic             a_hit,
   output logic             b_hit,
   output logic             w_same
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clear) begin
         q_vld <= 1'b0;
         q_vpn <= '0;
         q_ppn <= '0;
         q_rdm <= '0;
         q_wrm <= '0;
         q_for <= 1'b0;
         q_fow <= 1'b0;
         q_glb <= 1'b0;
         q_asn <= '0;
      end else if (wr_go) begin
         q_vld <= 1'b1;
         q_vpn <= d_vpn;
         q_ppn <= d_ppn;
         q_rdm <= d_rdm;
         q_wrm <= d_wrm;
         q_for <= d_for;
         q_fow <= d_fow;
         q_glb <= d_glb;
         q_asn <= d_asn;
      end else if (kill) begin
         q_vld <= 1'b0;
      end
   end

   always_comb begin
      a_hit  = q_vld && (q_vpn == a_vpn) && (q_glb || (q_asn == a_asn));
      b_hit  = q_vld && (q_vpn == b_vpn) && (q_glb || (q_asn == b_asn));
      w_same = q_vld && (q_vpn == d_vpn);
   end
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
   parameter int N = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            gnt[i] = 1'b1;
            idx    = IW'(i);
            any    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/xlat_rptr.sv
module xlat_rptr #(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zero,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (zero)    ptr <= '0;
      else if (step)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);

   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !zero) |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

   assert_ptr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      zero |=> (ptr == '0));
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
   import xlat_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int VPN_W = 30,
   parameter int PPN_W = 27,
   parameter int ASN_W = 7,
   parameter int MODES = 4,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [ASN_W-1:0] lk_asn,
   output logic             lk_hit,
   output logic [DEPTH-1:0] lk_hit_vec,
   output logic [PPN_W-1:0] lk_ppn,
   output logic [MODES-1:0] lk_rdm,
   output logic [MODES-1:0] lk_wrm,
   output logic             lk_for,
   output logic             lk_fow,
   output logic             lk_glb,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic [MODES-1:0] wr_rdm,
   input  logic [MODES-1:0] wr_wrm,
   input  logic             wr_for,
   input  logic             wr_fow,
   input  logic             wr_glb,
   input  logic [ASN_W-1:0] wr_asn,
   input  logic             fl_all,
   input  logic             fl_proc,
   input  logic             fl_addr,
   input  logic [VPN_W-1:0] fl_vpn,
   input  logic [ASN_W-1:0] fl_asn,
   input  logic             rb_adv,
   output logic [PTR_W-1:0] rb_ptr,
   output logic [PK_W-1:0]  rb_word
);
   initial begin
      if (DEPTH < 2)            $error("DEPTH must be at least 2");
      if (PPN_W > PK_PPN_MAX)   $error("PPN_W exceeds packed field");
      if (ASN_W > PK_ASN_MAX)   $error("ASN_W exceeds packed field");
      if (MODES > PK_MASK_MAX)  $error("MODES exceeds packed field");
   end

   logic             s_vld  [DEPTH];
   logic [VPN_W-1:0] s_vpn  [DEPTH];
   logic [PPN_W-1:0] s_ppn  [DEPTH];
   logic [MODES-1:0] s_rdm  [DEPTH];
   logic [MODES-1:0] s_wrm  [DEPTH];
   logic             s_for  [DEPTH];
   logic             s_fow  [DEPTH];
   logic             s_glb  [DEPTH];
   logic [ASN_W-1:0] s_asn  [DEPTH];
   logic [DEPTH-1:0] a_hit, b_hit, w_same, vld_vec;
   logic [PTR_W-1:0] hit_idx;
   logic             any_flush, ins_ok;

   assign any_flush = fl_all || fl_proc || fl_addr;
   assign ins_ok    = wr_en && !any_flush;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic kill_g;
      assign kill_g = (fl_proc && !s_glb[g]) || (fl_addr && b_hit[g]) ||
                      (ins_ok && w_same[g]);
      assign vld_vec[g] = s_vld[g];

      xlat_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr_go(ins_ok && (rb_ptr == PTR_W'(g))),
         .kill(kill_g), .clear(fl_all),
         .d_vpn(wr_vpn), .d_ppn(wr_ppn), .d_rdm(wr_rdm), .d_wrm(wr_wrm),
         .d_for(wr_for), .d_fow(wr_fow), .d_glb(wr_glb), .d_asn(wr_asn),
         .a_vpn(lk_vpn), .a_asn(lk_asn), .b_vpn(fl_vpn), .b_asn(fl_asn),
         .q_vld(s_vld[g]), .q_vpn(s_vpn[g]), .q_ppn(s_ppn[g]), .q_rdm(s_rdm[g]),
         .q_wrm(s_wrm[g]), .q_for(s_for[g]), .q_fow(s_fow[g]), .q_glb(s_glb[g]),
         .q_asn(s_asn[g]),
         .a_hit(a_hit[g]), .b_hit(b_hit[g]), .w_same(w_same[g])
      );
   end

   xlat_pick #(.N(DEPTH)) u_pick (
      .req(a_hit), .gnt(lk_hit_vec), .idx(hit_idx), .any(lk_hit)
   );

   xlat_rptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .zero(fl_all), .step(ins_ok || rb_adv), .ptr(rb_ptr)
   );

   always_comb begin
      lk_ppn = '0; lk_rdm = '0; lk_wrm = '0;
      lk_for = 1'b0; lk_fow = 1'b0; lk_glb = 1'b0;
      if (lk_hit) begin
         lk_ppn = s_ppn[hit_idx];
         lk_rdm = s_rdm[hit_idx];
         lk_wrm = s_wrm[hit_idx];
         lk_for = s_for[hit_idx];
         lk_fow = s_fow[hit_idx];
         lk_glb = s_glb[hit_idx];
      end
   end

   always_comb begin
      rb_word = '0;
      rb_word[PK_PPN_LSB +: PPN_W] = s_ppn[rb_ptr];
      rb_word[PK_RDM_LSB +: MODES] = s_rdm[rb_ptr];
      rb_word[PK_WRM_LSB +: MODES] = s_wrm[rb_ptr];
      rb_word[PK_FOR_BIT]          = s_for[rb_ptr];
      rb_word[PK_FOW_BIT]          = s_fow[rb_ptr];
      rb_word[PK_GLB_BIT]          = s_glb[rb_ptr];
      rb_word[PK_ASN_LSB +: ASN_W] = rb_word[PK_ASN_LSB +: ASN_W] | s_asn[rb_ptr];
   end

   logic [VPN_W-1:0] last_ins_vpn;
   logic [DEPTH-1:0] last_same, live_local;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_ins_vpn <= '0;
      else if (ins_ok) last_ins_vpn <= wr_vpn;
   end
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         last_same[i]  = s_vld[i] && (s_vpn[i] == last_ins_vpn);
         live_local[i] = s_vld[i] && !s_glb[i];
      end
   end

   assert_hit_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit ? $onehot(lk_hit_vec) : (lk_hit_vec == '0));

   assert_single_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ins_ok |=> ($countones(last_same) == 1));

   assert_flush_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fl_all |=> (vld_vec == '0));

   assert_flush_proc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fl_proc |=> (live_local == '0));

   assert_flush_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (fl_proc || fl_addr) && !fl_all && !rb_adv) |=> $stable(rb_ptr));
endmodule

// File: tb/sim_xlat_buf.sv
module sim_xlat_buf;
   localparam int CLK_NS = 10;
   localparam int D  = 4;
   localparam int VW = 12;
   localparam int PW = 27;
   localparam int AW = 7;
   localparam int MW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic [VW-1:0] lk_vpn = '0, wr_vpn = '0, fl_vpn = '0;
   logic [AW-1:0] lk_asn = '0, wr_asn = '0, fl_asn = '0;
   logic [PW-1:0] wr_ppn = '0, lk_ppn;
   logic [MW-1:0] wr_rdm = '0, wr_wrm = '0, lk_rdm, lk_wrm;
   logic wr_en = 0, wr_for = 0, wr_fow = 0, wr_glb = 0;
   logic fl_all = 0, fl_proc = 0, fl_addr = 0, rb_adv = 0;
   logic lk_hit, lk_for, lk_fow, lk_glb;
   logic [D-1:0] lk_hit_vec;
   logic [1:0] rb_ptr;
   logic [63:0] rb_word;

   xlat_buf #(.DEPTH(D), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODES(MW)) u0 (.*);

   int total = 0, bad = 0;

   // reference model
   logic          mv [D];
   logic [VW-1:0] mt [D];
   logic [PW-1:0] mp [D];
   logic [MW-1:0] mr [D], mw [D];
   logic          mfr [D], mfw [D], mg [D];
   logic [AW-1:0] ma [D];
   int            mptr = 0;

   typedef struct {
      string        rq;
      logic         hit;
      logic [D-1:0] vec;
      logic [PW-1:0] ppn;
      logic [63:0]  word;
      logic [1:0]   ptr;
   } item_t;
   item_t q[$];
   event chk_ev;

   function automatic logic [63:0] pack(int i);
      logic [63:0] w;
      w = '0;
      w |= 64'(mp[i]) << 32;
      w |= 64'(mr[i]) << 8;
      w |= 64'(mw[i]) << 12;
      w |= 64'(mfr[i]) << 1;
      w |= 64'(mfw[i]) << 2;
      w |= 64'(mg[i]) << 4;
      w |= 64'(ma[i]) << 57;
      return w;
   endfunction

   task automatic clear_slot(int i);
      mv[i] = 0; mt[i] = '0; mp[i] = '0; mr[i] = '0; mw[i] = '0;
      mfr[i] = 0; mfw[i] = 0; mg[i] = 0; ma[i] = '0;
   endtask

   task automatic tick();
      logic ins;
      logic kill [D];
      @(posedge clk);
      ins = wr_en && !(fl_all || fl_proc || fl_addr);
      for (int i = 0; i < D; i++)
         kill[i] = mv[i] && ((fl_proc && !mg[i]) ||
                   (fl_addr && mt[i] == fl_vpn && (mg[i] || ma[i] == fl_asn)) ||
                   (ins && mt[i] == wr_vpn));
      for (int i = 0; i < D; i++) begin
         if (fl_all) clear_slot(i);
         else if (kill[i]) mv[i] = 0;
      end
      if (ins) begin
         mv[mptr] = 1; mt[mptr] = wr_vpn; mp[mptr] = wr_ppn; mr[mptr] = wr_rdm;
         mw[mptr] = wr_wrm; mfr[mptr] = wr_for; mfw[mptr] = wr_fow;
         mg[mptr] = wr_glb; ma[mptr] = wr_asn;
      end
      if (fl_all) mptr = 0;
      else if (ins || rb_adv) mptr = (mptr + 1) % D;
      @(negedge clk);
      wr_en = 0; fl_all = 0; fl_proc = 0; fl_addr = 0; rb_adv = 0;
   endtask

   task automatic set_ins(input logic [VW-1:0] v, input logic [PW-1:0] p,
                          input logic [MW-1:0] r, input logic [MW-1:0] w,
                          input logic fr, input logic fw, input logic g,
                          input logic [AW-1:0] a);
      wr_en = 1; wr_vpn = v; wr_ppn = p; wr_rdm = r; wr_wrm = w;
      wr_for = fr; wr_fow = fw; wr_glb = g; wr_asn = a;
   endtask

   task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a, input string rq);
      item_t it;
      lk_vpn = v; lk_asn = a;
      #1;
      it.rq = rq; it.hit = 0; it.vec = '0; it.ppn = '0;
      for (int i = 0; i < D; i++)
         if (!it.hit && mv[i] && mt[i] == v && (mg[i] || ma[i] == a)) begin
            it.hit = 1; it.vec[i] = 1'b1; it.ppn = mp[i];
         end
      it.word = pack(mptr);
      it.ptr  = 2'(mptr);
      q.push_back(it);
      ->chk_ev;
      #1;
   endtask

   task automatic chk64(string rq, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // monitor
   initial forever begin
      item_t it;
      @(chk_ev);
      while (q.size() > 0) begin
         it = q.pop_front();
         chk64(it.rq, "hit", 64'(lk_hit), 64'(it.hit));
         chk64(it.rq, "hit_vec", 64'(lk_hit_vec), 64'(it.vec));
         chk64(it.rq, "ppn", 64'(lk_ppn), 64'(it.ppn));
         chk64(it.rq, "rb_word", rb_word, it.word);
         chk64(it.rq, "rb_ptr", 64'(rb_ptr), 64'(it.ptr));
      end
   end

   bit done = 0;
   initial begin
      #(CLK_NS * 100000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < D; i++) clear_slot(i);
      repeat (3) @(negedge clk);
      rst_n = 1;
      look(12'h005, 7'd1, "R11 reset empty");

      set_ins(12'h010, 27'h123, 4'hF, 4'h1, 1, 0, 0, 7'd1); tick();
      look(12'h010, 7'd1, "R1 asn match");
      look(12'h010, 7'd2, "R1 asn mismatch");
      set_ins(12'h020, 27'h5ABCDEF, 4'h3, 4'hC, 0, 1, 1, 7'd3); tick();
      look(12'h020, 7'd5, "R1 global any asn");
      set_ins(12'h030, 27'h0AA, 4'h2, 4'h2, 0, 0, 0, 7'd2); tick();
      set_ins(12'h031, 27'h0BB, 4'h4, 4'h8, 1, 1, 0, 7'd4); tick();
      look(12'h031, 7'd4, "R3 wrap to zero");
      // R8: hand-packed word for slot 0 (ppn 123, rdm F, wrm 1, for 1, asn 1)
      chk64("R8 hand packing", "rb_word", rb_word,
            (64'h123 << 32) | (64'hF << 8) | (64'h1 << 12) | 64'h2 | (64'd1 << 57));
      rb_adv = 1; tick();
      look(12'h010, 7'd1, "R9 advance keeps slots");
      // R8: slot 1 global entry, ppn top bits overlap the asn field
      chk64("R8 global packing", "rb_word", rb_word,
            (64'h5ABCDEF << 32) | (64'h3 << 8) | (64'hC << 12) | 64'h4 | 64'h10 | (64'd3 << 57));

      set_ins(12'h010, 27'h456, 4'h1, 4'h1, 0, 0, 0, 7'd2); tick();
      look(12'h010, 7'd2, "R4 new copy");
      look(12'h010, 7'd1, "R4 stale copy gone");

      set_ins(12'h040, 27'h777, 4'h5, 4'h5, 0, 0, 1, 7'd6); tick();
      fl_proc = 1; tick();
      look(12'h040, 7'd9, "R6 global survives");
      look(12'h031, 7'd4, "R6 local flushed");

      set_ins(12'h060, 27'h999, 4'h1, 4'h1, 0, 0, 0, 7'd1); fl_proc = 1; tick();
      look(12'h060, 7'd1, "R10 insert dropped by flush");
      set_ins(12'h061, 27'h998, 4'h1, 4'h1, 0, 0, 0, 7'd1); fl_addr = 1;
      fl_vpn = 12'h7FF; fl_asn = 7'd0; tick();
      look(12'h061, 7'd1, "R10 insert dropped by addr flush");

      set_ins(12'h050, 27'h321, 4'h6, 4'h6, 0, 0, 0, 7'd4); tick();
      fl_addr = 1; fl_vpn = 12'h050; fl_asn = 7'd5; tick();
      look(12'h050, 7'd4, "R7 wrong asn spares");
      fl_addr = 1; fl_vpn = 12'h040; fl_asn = 7'd9; tick();
      look(12'h040, 7'd9, "R7 global killed");
      look(12'h050, 7'd4, "R7 other slot kept");
      fl_addr = 1; fl_vpn = 12'h050; fl_asn = 7'd4; tick();
      look(12'h050, 7'd4, "R7 exact match killed");

      set_ins(12'h070, 27'h111, 4'h1, 4'h1, 0, 0, 0, 7'd1); tick();
      look(12'h070, 7'd1, "R2 single hit");
      fl_all = 1; tick();
      look(12'h070, 7'd1, "R5 flush all");

      #20;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule